// File: doc/BRIEF.md
# Serial Jacobi Eigen-Solver Sequencer

This block runs the full sweep sequence of a Jacobi eigenvalue decomposition on a small real symmetric N×N matrix (N even, at least 4). It owns two register matrices: a working matrix that converges towards the eigenvalues, and an eigenvector matrix that starts as identity. All arithmetic goes through one external rotation port. Through that port the sequencer asks for angle computations and for plane rotations of operand pairs. The port is request/acknowledge, so the rotation engine may take any number of cycles.

A run begins with a start pulse. The matrix is then streamed in row-major order, and only the upper triangle is kept, mirrored into the lower half. A fixed number of iterations follows. Each iteration computes N/2 angles, rotates the column pairs of the working matrix, rotates its row pairs, rotates the column pairs of the eigenvector matrix, and applies a round-robin permutation. Every index pair therefore meets in a diagonal 2×2 block once every N−1 iterations. At the end the block streams out the diagonal as eigenvalues, followed by the eigenvector matrix column by column.

Top module: `jac_eigen_seq`

## Requirements
- R1: After reset, busy, done, in_ready, out_valid and rot_req are all 0.
- R2: A start seen while idle raises busy and in_ready in the next cycle. It also loads the eigenvector matrix with identity, where a diagonal entry equals 2^FRAC (0x8000 by default) and every other entry is 0.
- R3: During loading, in_ready is 1 and the N² elements are taken in row-major order on in_valid. Element (r,c) with c ≥ r is written to positions (r,c) and (c,r). Elements with c < r are ignored. in_ready drops once the last element is taken.
- R4: An iteration begins with N/2 angle requests, k = 0 upward, each with rot_mode=0, rot_x=S[2k][2k], rot_y=S[2k+1][2k+1] and rot_z=S[2k][2k+1]. The rot_rx returned is stored as angle k.
- R5: Next come the column-pair rotations of S: for k, then for row r, a request with rot_mode=1, rot_flip=0, rot_x=S[r][2k], rot_y=S[r][2k+1] and rot_z=angle k. The results rot_rx and rot_ry replace those two entries.
- R6: Next come the row-pair rotations of S: for k, then for column c, a request with rot_flip=1, rot_x=S[2k][c], rot_y=S[2k+1][c] and rot_z=angle k, written back the same way.
- R7: Next the eigenvector matrix V receives the same column-pair sweep as R5, with rot_flip=0.
- R8: The iteration ends with a one-cycle permutation: S'[r][c]=S[m(r)][m(c)] and V'[r][c]=V[r][m(c)]. Here m(0)=0, m(2)=1, m(N−1)=N−2, m(k)=k−2 for any other even k, and m(k)=k+2 for any other odd k.
- R9: Exactly ITERS iterations run (default 15, the ceiling of 9+N·ln N for N=4) before any output appears.
- R10: The output stream gives S[k][k] for k = 0..N−1, then V[r][c] with c outer and r inner. out_last is on the final element. Data and out_last hold while out_valid is high and out_ready is low.
- R11: done is high for exactly the one cycle after the final element is taken, and busy is 0 in that cycle.
- R12: A start while busy has no effect on the sequence in progress.
- R13: A rotation request holds its mode, flip and operands until the cycle in which rot_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Input element accepted |
| in_data | input | DW | Matrix element, row-major |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Sink accepts output element |
| out_data | output | DW | Eigenvalue or eigenvector entry |
| out_last | output | 1 | Final output element |
| rot_req | output | 1 | Rotation request pending |
| rot_mode | output | 1 | 0 angle computation, 1 pair rotation |
| rot_flip | output | 1 | 1 for the row-side (transposed) rotation |
| rot_x | output | DW | First operand |
| rot_y | output | DW | Second operand |
| rot_z | output | DW | Third operand or angle |
| rot_ack | input | 1 | Request completed, results valid |
| rot_rx | input | DW | First result (angle in mode 0) |
| rot_ry | input | DW | Second result |

## Verification
The bench feeds the matrix with the lower triangle set to junk values. A block that stored the lower triangle would show different operands from the first angle request onward. It checks every rotation request against the predicted order and operands. This catches a pass run out of order, a pair and line index swapped, or a missing or wrong permutation, which only shows up from the second iteration on. Randomised rotation latency and output backpressure expose operands or output data that move before the handshake. A stray start pulse in mid-run, together with a check for exactly the predicted number of requests, exposes a restart and an off-by-one in the iteration count.

// File: rtl/jac_pkg.sv
package jac_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LOAD = 3'd1,
        PH_ANG  = 3'd2,
        PH_SCOL = 3'd3,
        PH_SROW = 3'd4,
        PH_VCOL = 3'd5,
        PH_PERM = 3'd6,
        PH_OUT  = 3'd7
    } jac_phase_e;

    localparam logic ROT_ANGLE = 1'b0;
    localparam logic ROT_APPLY = 1'b1;

endpackage

// File: rtl/jac_pair_fetch.sv
// Selects the two elements of one rotation pair from a matrix:
// column pass -> (line, 2p) and (line, 2p+1); row pass -> (2p, line) and (2p+1, line).
module jac_pair_fetch #(
    parameter int N  = 4,
    parameter int DW = 18,
    parameter int IW = $clog2(N),
    parameter int PW = $clog2(N/2)
) (
    input  logic [N-1:0][N-1:0][DW-1:0] mat,
    input  logic                        row_pass,
    input  logic [PW-1:0]               pair,
    input  logic [IW-1:0]               line,
    output logic [IW-1:0]               ra,
    output logic [IW-1:0]               ca,
    output logic [IW-1:0]               rb,
    output logic [IW-1:0]               cb,
    output logic [DW-1:0]               xa,
    output logic [DW-1:0]               xb
);
    logic [IW-1:0] lo, hi;

    always_comb begin
        lo = {pair, 1'b0};
        hi = {pair, 1'b1};
        ra = row_pass ? lo : line;
        ca = row_pass ? line : lo;
        rb = row_pass ? hi : line;
        cb = row_pass ? line : hi;
        xa = mat[ra][ca];
        xb = mat[rb][cb];
    end
endmodule

// File: rtl/jac_rr_perm.sv
// Round-robin reshuffle: slot 0 stays, the other slots move one step around a ring.
module jac_rr_perm #(
    parameter int N  = 4,
    parameter int DW = 18
) (
    input  logic [N-1:0][N-1:0][DW-1:0] s_in,
    input  logic [N-1:0][N-1:0][DW-1:0] v_in,
    output logic [N-1:0][N-1:0][DW-1:0] s_out,
    output logic [N-1:0][N-1:0][DW-1:0] v_out
);
    function automatic int src_of(input int k);
        if (k == 0)          return 0;
        else if (k == 2)     return 1;
        else if (k == N - 1) return N - 2;
        else if (k % 2 == 0) return k - 2;
        else                 return k + 2;
    endfunction

    for (genvar gr = 0; gr < N; gr++) begin : g_row
        for (genvar gc = 0; gc < N; gc++) begin : g_col
            localparam int SR = src_of(gr);
            localparam int SC = src_of(gc);
            assign s_out[gr][gc] = s_in[SR][SC];
            assign v_out[gr][gc] = v_in[gr][SC];
        end
    end
endmodule

// File: rtl/jac_eigen_seq.sv
module jac_eigen_seq
    import jac_pkg::*;
#(
    parameter int N     = 4,
    parameter int DW    = 18,
    parameter int FRAC  = 15,
    parameter int ITERS = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    output logic          rot_req,
    output logic          rot_mode,
    output logic          rot_flip,
    output logic [DW-1:0] rot_x,
    output logic [DW-1:0] rot_y,
    output logic [DW-1:0] rot_z,
    input  logic          rot_ack,
    input  logic [DW-1:0] rot_rx,
    input  logic [DW-1:0] rot_ry
);
    localparam int IW  = $clog2(N);
    localparam int PW  = $clog2(N/2);
    localparam int ITW = $clog2(ITERS);
    localparam logic [IW-1:0]  LAST  = IW'(N - 1);
    localparam logic [PW-1:0]  PLAST = PW'(N/2 - 1);
    localparam logic [ITW-1:0] ILAST = ITW'(ITERS - 1);
    localparam logic [DW-1:0]  ONE   = DW'(1) << FRAC;

    typedef logic [N-1:0][N-1:0][DW-1:0] mat_t;

    typedef struct packed {
        jac_phase_e                ph;
        mat_t                      s;
        mat_t                      v;
        logic [N/2-1:0][DW-1:0]    ang;
        logic [IW-1:0]             r;
        logic [IW-1:0]             c;
        logic [PW-1:0]             p;
        logic [IW-1:0]             t;
        logic [ITW-1:0]            it;
        logic                      oe;
        logic                      done;
    } st_t;

    st_t st_q, st_d;

    mat_t          s_perm, v_perm;
    logic [IW-1:0] s_ra, s_ca, s_rb, s_cb, v_ra, v_ca, v_rb, v_cb;
    logic [DW-1:0] s_xa, s_xb, v_xa, v_xb;
    logic [IW-1:0] blk_lo, blk_hi;
    jac_phase_e    sweep_next;

    jac_pair_fetch #(.N(N), .DW(DW), .IW(IW), .PW(PW)) s_fetch_i (
        .mat(st_q.s), .row_pass(st_q.ph == PH_SROW), .pair(st_q.p), .line(st_q.t),
        .ra(s_ra), .ca(s_ca), .rb(s_rb), .cb(s_cb), .xa(s_xa), .xb(s_xb)
    );

    jac_pair_fetch #(.N(N), .DW(DW), .IW(IW), .PW(PW)) v_fetch_i (
        .mat(st_q.v), .row_pass(1'b0), .pair(st_q.p), .line(st_q.t),
        .ra(v_ra), .ca(v_ca), .rb(v_rb), .cb(v_cb), .xa(v_xa), .xb(v_xb)
    );

    jac_rr_perm #(.N(N), .DW(DW)) perm_i (
        .s_in(st_q.s), .v_in(st_q.v), .s_out(s_perm), .v_out(v_perm)
    );

    assign blk_lo = {st_q.p, 1'b0};
    assign blk_hi = {st_q.p, 1'b1};

    always_comb begin
        case (st_q.ph)
            PH_SCOL: sweep_next = PH_SROW;
            PH_SROW: sweep_next = PH_VCOL;
            default: sweep_next = PH_PERM;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        rot_req   = 1'b0;
        rot_mode  = ROT_ANGLE;
        rot_flip  = 1'b0;
        rot_x     = '0;
        rot_y     = '0;
        rot_z     = '0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;

        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph = PH_LOAD;
                    st_d.r  = '0;
                    st_d.c  = '0;
                    for (int i = 0; i < N; i++) begin
                        for (int j = 0; j < N; j++) begin
                            st_d.v[i][j] = (i == j) ? ONE : '0;
                        end
                    end
                end
            end

            PH_LOAD: begin
                if (in_valid) begin
                    if (st_q.c >= st_q.r) begin
                        st_d.s[st_q.r][st_q.c] = in_data;
                        st_d.s[st_q.c][st_q.r] = in_data;
                    end
                    if (st_q.c == LAST) begin
                        st_d.c = '0;
                        if (st_q.r == LAST) begin
                            st_d.ph = PH_ANG;
                            st_d.p  = '0;
                            st_d.t  = '0;
                            st_d.it = '0;
                        end else begin
                            st_d.r = st_q.r + 1'b1;
                        end
                    end else begin
                        st_d.c = st_q.c + 1'b1;
                    end
                end
            end

            PH_ANG: begin
                rot_req = 1'b1;
                rot_x   = st_q.s[blk_lo][blk_lo];
                rot_y   = st_q.s[blk_hi][blk_hi];
                rot_z   = st_q.s[blk_lo][blk_hi];
                if (rot_ack) begin
                    st_d.ang[st_q.p] = rot_rx;
                    if (st_q.p == PLAST) begin
                        st_d.p  = '0;
                        st_d.t  = '0;
                        st_d.ph = PH_SCOL;
                    end else begin
                        st_d.p = st_q.p + 1'b1;
                    end
                end
            end

            PH_SCOL, PH_SROW, PH_VCOL: begin
                rot_req  = 1'b1;
                rot_mode = ROT_APPLY;
                rot_flip = (st_q.ph == PH_SROW);
                rot_x    = (st_q.ph == PH_VCOL) ? v_xa : s_xa;
                rot_y    = (st_q.ph == PH_VCOL) ? v_xb : s_xb;
                rot_z    = st_q.ang[st_q.p];
                if (rot_ack) begin
                    if (st_q.ph == PH_VCOL) begin
                        st_d.v[v_ra][v_ca] = rot_rx;
                        st_d.v[v_rb][v_cb] = rot_ry;
                    end else begin
                        st_d.s[s_ra][s_ca] = rot_rx;
                        st_d.s[s_rb][s_cb] = rot_ry;
                    end
                    if (st_q.t == LAST) begin
                        st_d.t = '0;
                        if (st_q.p == PLAST) begin
                            st_d.p  = '0;
                            st_d.ph = sweep_next;
                        end else begin
                            st_d.p = st_q.p + 1'b1;
                        end
                    end else begin
                        st_d.t = st_q.t + 1'b1;
                    end
                end
            end

            PH_PERM: begin
                st_d.s = s_perm;
                st_d.v = v_perm;
                if (st_q.it == ILAST) begin
                    st_d.ph = PH_OUT;
                    st_d.r  = '0;
                    st_d.c  = '0;
                    st_d.oe = 1'b1;
                end else begin
                    st_d.it = st_q.it + 1'b1;
                    st_d.ph = PH_ANG;
                end
            end

            PH_OUT: begin
                out_valid = 1'b1;
                out_data  = st_q.oe ? st_q.s[st_q.c][st_q.c] : st_q.v[st_q.r][st_q.c];
                out_last  = !st_q.oe && (st_q.r == LAST) && (st_q.c == LAST);
                if (out_ready) begin
                    if (st_q.oe) begin
                        if (st_q.c == LAST) begin
                            st_d.oe = 1'b0;
                            st_d.c  = '0;
                            st_d.r  = '0;
                        end else begin
                            st_d.c = st_q.c + 1'b1;
                        end
                    end else if (st_q.r == LAST) begin
                        st_d.r = '0;
                        if (st_q.c == LAST) begin
                            st_d.ph   = PH_IDLE;
                            st_d.done = 1'b1;
                        end else begin
                            st_d.c = st_q.c + 1'b1;
                        end
                    end else begin
                        st_d.r = st_q.r + 1'b1;
                    end
                end
            end

            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = (st_q.ph != PH_IDLE);
    assign done     = st_q.done;
    assign in_ready = (st_q.ph == PH_LOAD);
endmodule

// File: rtl/jac_eigen_seq_chk.sv
module jac_eigen_seq_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_last,
    input logic          rot_req,
    input logic          rot_ack,
    input logic          rot_mode,
    input logic          rot_flip,
    input logic [DW-1:0] rot_x,
    input logic [DW-1:0] rot_y,
    input logic [DW-1:0] rot_z
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !out_valid && !rot_req));

    // R3
    load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && !rot_req && !out_valid));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R11
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (done && !busy));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_req && !rot_ack) |=> (rot_req && $stable(rot_mode) && $stable(rot_flip)
                                   && $stable(rot_x) && $stable(rot_y) && $stable(rot_z)));
endmodule

bind jac_eigen_seq jac_eigen_seq_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .rot_req(rot_req), .rot_ack(rot_ack), .rot_mode(rot_mode), .rot_flip(rot_flip),
    .rot_x(rot_x), .rot_y(rot_y), .rot_z(rot_z)
);

// File: tb/jac_eigen_seq_tb_top.sv
module jac_eigen_seq_tb_top;
    localparam int N     = 4;
    localparam int DW    = 18;
    localparam int FRAC  = 15;
    localparam int ITERS = 15;
    localparam int RW    = 2 + 3*DW;

    logic clk = 1'b0;
    logic rst_n, start, busy, done, in_valid, in_ready;
    logic [DW-1:0] in_data, out_data, rot_x, rot_y, rot_z, rot_rx, rot_ry;
    logic out_valid, out_ready, out_last, rot_req, rot_mode, rot_flip, rot_ack;

    always #5 clk = ~clk;

    jac_eigen_seq #(.N(N), .DW(DW), .FRAC(FRAC), .ITERS(ITERS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .rot_req(rot_req), .rot_mode(rot_mode), .rot_flip(rot_flip),
        .rot_x(rot_x), .rot_y(rot_y), .rot_z(rot_z),
        .rot_ack(rot_ack), .rot_rx(rot_rx), .rot_ry(rot_ry)
    );

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;

    logic [RW-1:0] exp_req[$];
    string         exp_tag[$];
    logic [DW:0]   exp_out[$];
    logic [DW-1:0] in_mat[N][N];
    logic [DW-1:0] rs[N][N];
    logic [DW-1:0] rv[N][N];
    logic [DW-1:0] rang[N/2];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] f_ang(input logic [DW-1:0] x, y, z);
        return z + y - {x[DW-1], x[DW-1:1]};
    endfunction

    function automatic logic [2*DW-1:0] f_rot(input logic [DW-1:0] x, y, z, input logic flip);
        logic [DW-1:0] a, b;
        if (flip) begin a = y - z; b = x + (z << 1); end
        else      begin a = y + z; b = x - z; end
        return {a, b};
    endfunction

    function automatic int rr_src(input int k);
        if (k == 0) return 0;
        if (k == 2) return 1;
        if (k == N - 1) return N - 2;
        if (k % 2 == 0) return k - 2;
        return k + 2;
    endfunction

    // Behavioural reference: predicts every rotation request and every output element.
    task automatic build_ref();
        logic [DW-1:0] ts[N][N];
        logic [DW-1:0] tv[N][N];
        logic [2*DW-1:0] res;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                rv[r][c] = (r == c) ? (DW'(1) << FRAC) : '0;
                if (c >= r) begin rs[r][c] = in_mat[r][c]; rs[c][r] = in_mat[r][c]; end
            end
        for (int it = 0; it < ITERS; it++) begin
            for (int k = 0; k < N/2; k++) begin
                exp_req.push_back({1'b0, 1'b0, rs[2*k][2*k], rs[2*k+1][2*k+1], rs[2*k][2*k+1]});
                exp_tag.push_back(it == 0 ? "R4 angle" : "R8 angle after permute");
                rang[k] = f_ang(rs[2*k][2*k], rs[2*k+1][2*k+1], rs[2*k][2*k+1]);
            end
            for (int k = 0; k < N/2; k++)
                for (int r = 0; r < N; r++) begin
                    exp_req.push_back({1'b1, 1'b0, rs[r][2*k], rs[r][2*k+1], rang[k]});
                    exp_tag.push_back("R5 S column");
                    res = f_rot(rs[r][2*k], rs[r][2*k+1], rang[k], 1'b0);
                    rs[r][2*k] = res[2*DW-1:DW]; rs[r][2*k+1] = res[DW-1:0];
                end
            for (int k = 0; k < N/2; k++)
                for (int c = 0; c < N; c++) begin
                    exp_req.push_back({1'b1, 1'b1, rs[2*k][c], rs[2*k+1][c], rang[k]});
                    exp_tag.push_back("R6 S row");
                    res = f_rot(rs[2*k][c], rs[2*k+1][c], rang[k], 1'b1);
                    rs[2*k][c] = res[2*DW-1:DW]; rs[2*k+1][c] = res[DW-1:0];
                end
            for (int k = 0; k < N/2; k++)
                for (int r = 0; r < N; r++) begin
                    exp_req.push_back({1'b1, 1'b0, rv[r][2*k], rv[r][2*k+1], rang[k]});
                    exp_tag.push_back(it == 0 ? "R2 R7 V column" : "R7 V column");
                    res = f_rot(rv[r][2*k], rv[r][2*k+1], rang[k], 1'b0);
                    rv[r][2*k] = res[2*DW-1:DW]; rv[r][2*k+1] = res[DW-1:0];
                end
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    ts[r][c] = rs[rr_src(r)][rr_src(c)];
                    tv[r][c] = rv[r][rr_src(c)];
                end
            rs = ts;
            rv = tv;
        end
        for (int k = 0; k < N; k++) exp_out.push_back({1'b0, rs[k][k]});
        for (int c = 0; c < N; c++)
            for (int r = 0; r < N; r++)
                exp_out.push_back({(r == N-1) && (c == N-1), rv[r][c]});
    endtask

    // Rotation engine with variable latency
    initial begin
        logic [15:0] lf;
        logic [DW-1:0] sx, sy, sz;
        logic smode, sflip;
        int wait_n;
        bit seen;
        lf = 16'hACE1; seen = 0; wait_n = 0;
        sx = '0; sy = '0; sz = '0; smode = 0; sflip = 0;
        rot_ack = 1'b0; rot_rx = '0; rot_ry = '0;
        forever begin
            @(negedge clk);
            if (rot_ack) begin
                rot_ack = 1'b0;
            end else if (rot_req && rst_n) begin
                if (!seen) begin
                    seen = 1;
                    if (exp_req.size() == 0) begin
                        chk("R9 unexpected extra request", 64'(rot_req), 64'(0));
                    end else begin
                        chk(exp_tag.pop_front(), 64'({rot_mode, rot_flip, rot_x, rot_y, rot_z}),
                            64'(exp_req.pop_front()));
                    end
                    sx = rot_x; sy = rot_y; sz = rot_z; smode = rot_mode; sflip = rot_flip;
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    wait_n = int'(lf[1:0]);
                end
                if (wait_n == 0) begin
                    chk("R13 request held", 64'({rot_mode, rot_flip, rot_x, rot_y, rot_z}),
                        64'({smode, sflip, sx, sy, sz}));
                    if (!rot_mode) begin
                        rot_rx = f_ang(rot_x, rot_y, rot_z);
                        rot_ry = '0;
                    end else begin
                        {rot_rx, rot_ry} = f_rot(rot_x, rot_y, rot_z, rot_flip);
                    end
                    rot_ack = 1'b1;
                    seen = 0;
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // Output sink with backpressure and done-pulse tracking
    initial begin
        logic [15:0] lf;
        bit last_hs;
        lf = 16'h1F3B; last_hs = 0;
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk("R11 done pulse", 64'(done), 64'(last_hs));
                if (last_hs) chk("R11 busy low with done", 64'(busy), 64'(0));
            end
            last_hs = 0;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            out_ready = (rdy_mode == 0) ? 1'b1 : lf[0];
            if (out_valid && out_ready) begin
                if (exp_out.size() == 0) begin
                    chk("R10 unexpected output", 64'(out_valid), 64'(0));
                end else begin
                    chk("R10 output element", 64'({out_last, out_data}), 64'(exp_out.pop_front()));
                end
                last_hs = out_last;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        lf = 16'h7A55;
        rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 64'({busy, done, in_ready, out_valid, rot_req}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 64'({busy, done, in_ready, out_valid, rot_req}), 64'(0));

        for (int run = 0; run < 3; run++) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    if (run == 2)      in_mat[r][c] = '0;
                    else if (c < r)    in_mat[r][c] = DW'(18'h2A5A5 ^ (r * 7 + c));
                    else if (run == 0) in_mat[r][c] = DW'(r * 16 + c + 1);
                    else               in_mat[r][c] = {lf[1:0], lf};
                end
            if (run == 2) in_mat[3][0] = DW'(18'h12345);
            build_ref();
            rdy_mode = run;

            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R2 busy and in_ready after start", 64'({busy, in_ready}), 64'(2'b11));

            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    if ((r + c + run) % 3 == 1) begin
                        in_valid = 1'b0;
                        @(negedge clk);
                    end
                    chk("R3 in_ready during load", 64'(in_ready), 64'(1));
                    in_valid = 1'b1;
                    in_data  = in_mat[r][c];
                    @(negedge clk);
                end
            in_valid = 1'b0;
            chk("R3 in_ready low after last element", 64'(in_ready), 64'(0));

            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R12 start while busy ignored", 64'({busy, in_ready}), 64'(2'b10));

            forever begin
                @(negedge clk);
                if (done) break;
                chk("R12 busy held during run", 64'(busy), 64'(1));
            end
            chk("R9 all predicted requests issued", 64'(exp_req.size()), 64'(0));
            chk("R10 all predicted outputs seen", 64'(exp_out.size()), 64'(0));
            repeat (2) @(negedge clk);
            chk("R11 idle after run", 64'({busy, done, out_valid, rot_req}), 64'(0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule